// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A general-purpose interval timer built from a small prescale counter feeding a wide down counter. The prescale counter steps down on every clock and, each time it passes zero, reloads from a programmable divide value and lets the main counter step down by one. When the main counter passes zero it reloads from a period register and raises a one-clock interrupt pulse together with an identical one-clock timer output pulse. The interrupt repeats every (period + 1) x (divide + 1) clocks.

Software reaches the block through a simple write/read port with three registers: the live counter, the period and a control word. The control word carries a stop bit, a self-clearing reload bit, the divide value, two debug-halt policy bits and a read-only view of the running prescale count. A stop takes effect only after two control writes in a row that both set the stop bit, so one stray write cannot freeze the timer. A halt input from a debug controller can freeze the timer at once, let it run down to zero and then hold, or be ignored, depending on the two policy bits. Reading the counter and reading the prescale count are two separate accesses and are not taken as one snapshot.

Top module: `tmr_prescaled`

## Requirements
- R1: After reset the control word reads 0 (stop bit clear, divide 0, policy bits 0), the period reads all ones, and the counter decrements by one on every clock from the first clock after reset is released.
- R2: A single control write with the stop bit (bit 4) set leaves the timer running and the stop bit still reads 0.
- R3: A second control write in a row with bit 4 set stops the timer: counter and prescale count hold, no pulse is produced, and bit 4 reads 1; a control write with bit 4 clear lets it run again.
- R4: While running, the prescale count steps down every clock and reloads from the divide field after reaching 0; the counter steps down once per divide+1 clocks and reloads from the period after reaching 0, so pulses repeat every (period+1) x (divide+1) clocks.
- R5: On each counter underflow the interrupt and the timer output are both high for exactly one clock, in the same clock.
- R6: A control write with the reload bit (bit 5) set loads the counter from the period register and the prescale count from the divide field written in the same access, even while stopped; bit 5 always reads 0.
- R7: With the halt input high, free bit (bit 10) 0 and soft bit (bit 11) 0, counting freezes on the next clock and resumes when halt falls.
- R8: With the halt input high, free bit 0 and soft bit 1, counting continues until the counter reads 0 and then holds there without an underflow; the underflow comes on the first clock after halt falls.
- R9: With the free bit 1, the halt input has no effect on counting or on pulse timing.
- R10: Address 0 reads and writes the counter, address 1 the period, address 2 the control word laid out as prescale count [3:0] (read-only), stop 4, reload 5, divide [9:6], free 10, soft 11; address 3 reads 0. A write to address 0 sets the counter directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| addr | input | 2 | Register select for writes and reads |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the selected register, combinational |
| halt_i | input | 1 | Halt request from the debug controller |
| irq_o | output | 1 | One-clock interrupt pulse on underflow |
| tout_o | output | 1 | One-clock timer output pulse on underflow |

## Verification
On every cycle the assertions check that a stop only happens after an armed write, that a stopped or hard-halted timer holds both counts and stays silent, that a soft halt holds a zero counter without underflow, that a reload lands the period and the written divide, and that pulses never repeat back to back unless the period and divide are both zero. Pulse spacing as a function of period and divide, the resumption after stop and halt, the free-running case under halt, the reset state and the exact read layout of the control word are shown only by the bench's scenarios, which predict each pulse time and compare register reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Control word layout; software decodes these positions
   localparam int unsigned CTL_PSC_LSB = 0;
   localparam int unsigned CTL_STOP    = 4;
   localparam int unsigned CTL_RELOAD  = 5;
   localparam int unsigned CTL_DIV_LSB = 6;
   localparam int unsigned CTL_FREE    = 10;
   localparam int unsigned CTL_SOFT    = 11;
   localparam int unsigned CTL_USED_W  = 12;
   localparam int unsigned PSC_MAX_W   = CTL_STOP - CTL_PSC_LSB;

   typedef enum logic [1:0] {
      REG_COUNT  = 2'd0,
      REG_PERIOD = 2'd1,
      REG_CTRL   = 2'd2,
      REG_NONE   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [PSC_W-1:0] load_val,
   input  logic [PSC_W-1:0] div_q,
   output logic [PSC_W-1:0] psc_q,
   output logic             tick
);

   localparam logic [PSC_W-1:0] PSC_ZERO = '0;

   assign tick = run && !load && (psc_q == PSC_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q <= PSC_ZERO;
      end else if (load) begin
         psc_q <= load_val;
      end else if (run) begin
         if (psc_q == PSC_ZERO) psc_q <= div_q;
         else                   psc_q <= psc_q - 1'b1;
      end
   end

endmodule

// File: rtl/tmr_down_count.sv
module tmr_down_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             underflow
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   assign underflow = tick && !load && !wr && (cnt_q == CNT_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (wr) begin
         cnt_q <= wr_val;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         if (cnt_q == CNT_ZERO) cnt_q <= load_val;
         else                   cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] period_q,
   output logic [PSC_W-1:0] div_q,
   output logic             free_q,
   output logic             soft_q,
   output logic             stopped_q,
   output logic             armed_q,
   output logic             reload_req,
   output logic [PSC_W-1:0] reload_div,
   output logic             count_wr
);

   logic wr_ctl;
   logic wr_per;

   assign wr_ctl     = wr_en && (reg_sel_e'(addr) == REG_CTRL);
   assign wr_per     = wr_en && (reg_sel_e'(addr) == REG_PERIOD);
   assign count_wr   = wr_en && (reg_sel_e'(addr) == REG_COUNT);
   assign reload_req = wr_ctl && wdata[CTL_RELOAD];
   assign reload_div = wdata[CTL_DIV_LSB +: PSC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
      end else if (wr_per) begin
         period_q <= wdata;
      end
   end

   // Stop arming: first write with stop set arms, second one stops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         free_q    <= 1'b0;
         soft_q    <= 1'b0;
         stopped_q <= 1'b0;
         armed_q   <= 1'b0;
      end else if (wr_ctl) begin
         div_q  <= wdata[CTL_DIV_LSB +: PSC_W];
         free_q <= wdata[CTL_FREE];
         soft_q <= wdata[CTL_SOFT];
         if (wdata[CTL_STOP]) begin
            armed_q <= 1'b1;
            if (armed_q) stopped_q <= 1'b1;
         end else begin
            armed_q   <= 1'b0;
            stopped_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tmr_prescaled.sv
module tmr_prescaled
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PSC_W     = 4,
   parameter bit          HALT_SYNC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   input  logic             halt_i,
   output logic             irq_o,
   output logic             tout_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   if (CNT_W < CTL_USED_W) begin : g_bad_cnt_w
      $error("tmr_prescaled: CNT_W must hold the control word");
   end
   if (PSC_W < 1 || PSC_W > PSC_MAX_W) begin : g_bad_psc_w
      $error("tmr_prescaled: PSC_W out of range for the control word");
   end

   logic             halt_eff;
   logic [CNT_W-1:0] period_q;
   logic [PSC_W-1:0] div_q;
   logic             free_q;
   logic             soft_q;
   logic             stopped_q;
   logic             armed_q;
   logic             reload_req;
   logic [PSC_W-1:0] reload_div;
   logic             count_wr;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             underflow;
   logic             halt_block;
   logic             run;
   logic             irq_q;
   logic             tout_q;
   logic [CNT_W-1:0] ctl_view;

   // Optional synchronizer for a halt coming from another clock domain
   if (HALT_SYNC) begin : g_halt_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= 2'b00;
         else        sync_q <= {sync_q[0], halt_i};
      end
      assign halt_eff = sync_q[1];
   end else begin : g_halt_direct
      assign halt_eff = halt_i;
   end

   tmr_ctl_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .period_q   (period_q),
      .div_q      (div_q),
      .free_q     (free_q),
      .soft_q     (soft_q),
      .stopped_q  (stopped_q),
      .armed_q    (armed_q),
      .reload_req (reload_req),
      .reload_div (reload_div),
      .count_wr   (count_wr)
   );

   // Debug halt policy: free ignores halt; soft runs down to zero first
   assign halt_block = halt_eff && !free_q && (!soft_q || (cnt_q == CNT_ZERO));
   assign run        = !stopped_q && !halt_block;

   tmr_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .load     (reload_req),
      .load_val (reload_div),
      .div_q    (div_q),
      .psc_q    (psc_q),
      .tick     (tick)
   );

   tmr_down_count #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (reload_req),
      .load_val  (period_q),
      .wr        (count_wr),
      .wr_val    (wdata),
      .cnt_q     (cnt_q),
      .underflow (underflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         tout_q <= 1'b0;
      end else begin
         irq_q  <= underflow;
         tout_q <= underflow;
      end
   end

   assign irq_o  = irq_q;
   assign tout_o = tout_q;

   always_comb begin
      ctl_view = '0;
      ctl_view[CTL_PSC_LSB +: PSC_W] = psc_q;
      ctl_view[CTL_STOP]             = stopped_q;
      ctl_view[CTL_DIV_LSB +: PSC_W] = div_q;
      ctl_view[CTL_FREE]             = free_q;
      ctl_view[CTL_SOFT]             = soft_q;
   end

   always_comb begin
      case (reg_sel_e'(addr))
         REG_COUNT:  rdata = cnt_q;
         REG_PERIOD: rdata = period_q;
         REG_CTRL:   rdata = ctl_view;
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_prescaled_chk.sv
module tmr_prescaled_chk
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PSC_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [CNT_W-1:0] wdata,
   input logic             halt_eff,
   input logic             irq_o,
   input logic [CNT_W-1:0] cnt_q,
   input logic [PSC_W-1:0] psc_q,
   input logic [CNT_W-1:0] period_q,
   input logic [PSC_W-1:0] div_q,
   input logic             free_q,
   input logic             soft_q,
   input logic             stopped_q,
   input logic             armed_q
);

   AST_STOP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped_q) |-> $past(armed_q)); // R3

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stopped_q && !wr_en |=> $stable(cnt_q) && $stable(psc_q) && !irq_o); // R3

   AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (addr == REG_CTRL) && wdata[CTL_RELOAD]
      |=> (cnt_q == $past(period_q)) && (psc_q == $past(wdata[CTL_DIV_LSB +: PSC_W]))); // R6

   AST_HARD_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_eff && !free_q && !soft_q && !wr_en
      |=> $stable(cnt_q) && $stable(psc_q) && !irq_o); // R7

   AST_SOFT_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halt_eff && !free_q && soft_q && (cnt_q == '0) && !wr_en
      |=> (cnt_q == '0) && !irq_o); // R8

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && $stable(period_q) && $stable(div_q) && ((period_q != '0) || (div_q != '0))
      |=> !irq_o); // R5

endmodule

bind tmr_prescaled tmr_prescaled_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .halt_eff  (halt_eff),
   .irq_o     (irq_o),
   .cnt_q     (cnt_q),
   .psc_q     (psc_q),
   .period_q  (period_q),
   .div_q     (div_q),
   .free_q    (free_q),
   .soft_q    (soft_q),
   .stopped_q (stopped_q),
   .armed_q   (armed_q)
);

// File: tb/tb_tmr_prescaled.sv
`timescale 1ns/1ps
module tb_tmr_prescaled;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd3;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        halt_i = 1'b0;
   logic        irq_o;
   logic        tout_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_q[$];

   tmr_prescaled dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .halt_i(halt_i), .irq_o(irq_o), .tout_o(tout_o)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
      end
   endtask

   function automatic logic [15:0] ctl(input bit stop, input bit rld, input int dv,
                                       input bit fr, input bit sf);
      logic [15:0] v;
      v = '0;
      v[4] = stop; v[5] = rld; v[9:6] = dv[3:0]; v[10] = fr; v[11] = sf;
      return v;
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // Monitor: pops expected pulse times as pulses appear
   always @(negedge clk) begin
      if (rst_n && (irq_o || tout_o)) begin
         check("R5 tout_o equals irq_o", int'(tout_o), int'(irq_o));
         if (irq_o) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R4: unexpected pulse at cycle %0d, expected none", cyc);
            end else begin
               check("R4 pulse cycle", cyc, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v1, v2, v3, v4;
      int e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and free running from reset
      rd(2'd2, v1); check("R1 control after reset", v1, 0);
      rd(2'd1, v1); check("R1 period after reset", v1, 16'hFFFF);
      rd(2'd0, v1); rd(2'd0, v2);
      check("R1 counter steps each clock", v2, (v1 - 16'd1) & 16'hFFFF);

      // R4/R6: prescaled periodic pulses, period 4 divide 2 -> every 15
      wr(2'd1, 16'd4);
      wr(2'd2, ctl(0, 1, 2, 0, 0)); e = cyc;
      exp_q.push_back(e + 15); exp_q.push_back(e + 30); exp_q.push_back(e + 45);
      rd(2'd2, v1); check("R6 reload bit reads 0", int'(v1[5]), 0);
      check("R10 divide field readback", int'(v1[9:6]), 2);
      wait_until(e + 47);

      // R2/R3: stop needs two writes
      wr(2'd1, 16'd20);
      wr(2'd2, ctl(0, 1, 3, 0, 0));
      wr(2'd2, ctl(1, 0, 3, 0, 0));
      rd(2'd0, v1); repeat (3) @(negedge clk); rd(2'd0, v2);
      check("R2 single stop write keeps counting", int'(v2 != v1), 1);
      rd(2'd2, v3); check("R2 stop bit still 0", int'(v3[4]), 0);
      wr(2'd2, ctl(1, 0, 3, 0, 0));
      rd(2'd2, v3); check("R3 stop bit reads 1", int'(v3[4]), 1);
      rd(2'd0, v3); repeat (100) @(negedge clk); rd(2'd0, v4);
      check("R3 counter holds while stopped", v4, v3);
      wr(2'd0, 16'h1234);
      rd(2'd0, v1); check("R10 direct counter write", v1, 16'h1234);
      wr(2'd2, ctl(1, 1, 3, 0, 0));
      rd(2'd0, v1); check("R6 reload while stopped loads period", v1, 20);
      rd(2'd2, v1); check("R10 control view with prescale count", v1, ctl(1, 0, 3, 0, 0) | 16'd3);
      rd(2'd3, v1); check("R10 unused address reads 0", v1, 0);
      wr(2'd2, ctl(0, 1, 3, 0, 0)); e = cyc;
      exp_q.push_back(e + 84);
      rd(2'd2, v1); check("R3 stop cleared by write of 0", int'(v1[4]), 0);
      wait_until(e + 85);

      // R7: hard halt freezes
      wr(2'd1, 16'd1000);
      wr(2'd2, ctl(0, 1, 0, 0, 0));
      repeat (5) @(negedge clk);
      @(negedge clk); halt_i = 1'b1;
      rd(2'd0, v1); repeat (20) @(negedge clk); rd(2'd0, v2);
      check("R7 counter frozen under halt", v2, v1);
      halt_i = 1'b0;
      repeat (5) @(negedge clk); rd(2'd0, v3);
      check("R7 counting resumes after halt", v3, v2 - 16'd6);

      // R8: soft halt runs to zero then holds
      wr(2'd1, 16'd10);
      @(negedge clk); halt_i = 1'b1;
      wr(2'd2, ctl(0, 1, 0, 0, 1)); e = cyc;
      wait_until(e + 30);
      rd(2'd0, v1); check("R8 counter holds at zero", v1, 0);
      @(negedge clk); halt_i = 1'b0;
      exp_q.push_back(cyc + 1);
      wait_until(cyc + 2);

      // R9: free bit ignores halt, period 5 divide 1 -> every 12
      wr(2'd1, 16'd5);
      halt_i = 1'b1;
      wr(2'd2, ctl(0, 1, 1, 1, 0)); e = cyc;
      exp_q.push_back(e + 12); exp_q.push_back(e + 24);
      rd(2'd2, v1); check("R9 free bit readback", int'(v1[10]), 1);
      wait_until(e + 26);
      halt_i = 1'b0;

      check("R4 all expected pulses seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule